// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block collects interrupt requests from eight fixed sources of a small embedded processor and selects one winner. It presents the winner to the CPU as a request flag, a source index and a program-memory vector address. Seven sources arrive as plain request lines: two external pins, two timers, two DMA channels and a serial port. The eighth is the FIFO/slave-interface source. The block builds it from the status flags of an input FIFO and an output FIFO and from a flag that shows a data-stream command is waiting.

Software sets up the block through a small register write port. One register holds the enables of the five legacy sources and the master enable. A second holds their priority bits. A third holds the enable and priority bits of the three added sources (FIFO, DMA 0, DMA 1). A fourth, the slave-control register, chooses which FIFO conditions raise a request. Every source has a one-bit priority level. In-service tracking for each level decides which requests may interrupt a handler that is already running. The CPU acknowledges the presented request and later signals return from the handler.

Top module: `octo_irq_ctrl`

## Requirements
- R1: After reset, `int_req`, `int_src` and `int_vector` are zero and every configuration bit is cleared, so the master enable is off and no request is presented.
- R2: Register map, written when `cfg_we` is high:
  - Address 0 holds the legacy enables (bit0 ext0, bit1 timer0, bit2 ext1, bit3 timer1, bit4 serial) and the master enable in bit7.
  - Address 1 holds the legacy priority bits at the same positions.
  - Address 2 holds the added-source enables (bit0 FIFO, bit1 DMA0, bit2 DMA1) and their priority bits (bit4 FIFO, bit5 DMA0, bit6 DMA1).
  - Address 3 is slave control: bit0 output-empty select, bit1 input-full select, bit2 input-FIFO service enable, bit3 output-FIFO service enable, bit4 command enable.
  - A source counts only when its own enable bit is 1.
- R3: When the master enable is 0, no source is presented, including the three added sources.
- R4: An eligible source whose priority bit is 1 (high level) always wins over any source whose priority bit is 0 (low level).
- R5: Within one level the tie order, highest first, is ext0, timer0, DMA0, ext1, DMA1, timer1, FIFO, serial. `int_src` reports this position as 0 to 7.
- R6: The vectors are 0x03 ext0, 0x0B timer0, 0x13 ext1, 0x1B timer1, 0x23 serial, 0x2B FIFO, 0x33 DMA0 and 0x3B DMA1.
- R7: With the input-FIFO service enable set, the input FIFO requests service when it is full if the input-full select is 1, and when it is not empty if that select is 0.
- R8: With the output-FIFO service enable set, the output FIFO requests service when it is empty if the output-empty select is 1, and when it is not full if that select is 0.
- R9: A waiting data-stream command raises the FIFO source only while the command enable is set. The FIFO source is presented only if it is also enabled at address 2.
- R10: Request timing and hold:
  - A request line is captured at a clock edge.
  - The winner appears on `int_req`/`int_src`/`int_vector` at the following edge.
  - While `int_req` is high and `int_ack` is low, these three outputs hold their values, even if a stronger request arrives.
- R11: Acknowledge:
  - `int_ack` while `int_req` is high drops `int_req` at the next edge, marks the presented level as in service and clears the pending flag of an edge-type source.
  - Edge-type sources are ext0, timer0, DMA0, ext1, DMA1 and timer1. Such a source requests again only after its line goes low and then high.
  - `int_ack` while `int_req` is low has no effect.
- R12: Level-type sources (FIFO, serial) stay pending after acknowledge for as long as their condition holds.
- R13: In-service rules and return:
  - While a low-level handler is in service, only high-level sources may be presented.
  - While a high-level handler is in service, none may be presented.
  - `int_reti` clears the high-level in-service flag if it is set, and otherwise the low-level flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ext0 | input | 1 | External request 0 line |
| req_tmr0 | input | 1 | Timer 0 request line |
| req_dma0 | input | 1 | DMA channel 0 request line |
| req_ext1 | input | 1 | External request 1 line |
| req_dma1 | input | 1 | DMA channel 1 request line |
| req_tmr1 | input | 1 | Timer 1 request line |
| req_serial | input | 1 | Serial port request line |
| in_full | input | 1 | Input FIFO is full |
| in_empty | input | 1 | Input FIFO is empty |
| out_full | input | 1 | Output FIFO is full |
| out_empty | input | 1 | Output FIFO is empty |
| cmd_pending | input | 1 | A data-stream command is waiting |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| int_ack | input | 1 | CPU accepts the presented request |
| int_reti | input | 1 | CPU returns from a handler |
| int_req | output | 1 | A request is presented |
| int_src | output | 3 | Tie-order position of the presented source |
| int_vector | output | 8 | Vector address of the presented source |

## Verification
The hardest condition to reach from the ports is nesting: a low-level handler in service, with a high-level handler stacked on it and further requests waiting at both levels. The stimulus reaches it by acknowledging a low-level external request and then raising a high-level timer. It acknowledges that timer too and raises a high-level DMA request that must stay blocked. Single return pulses then unwind the stack one level at a time, and the expected vector is checked at each step. Separate runs cover the difference between edge-type and level-type sources: lines are held high across an acknowledge, and a FIFO condition is removed between acknowledge and return.

// File: rtl/octo_irq_pkg.sv
package octo_irq_pkg;

   localparam int unsigned NSRC   = 8;
   localparam int unsigned SRC_W  = 3;
   localparam int unsigned CFG_DW = 8;
   localparam int unsigned CFG_AW = 2;

   // tie-break position, highest first
   typedef enum logic [SRC_W-1:0] {
      S_EXT0 = 3'd0,
      S_TMR0 = 3'd1,
      S_DMA0 = 3'd2,
      S_EXT1 = 3'd3,
      S_DMA1 = 3'd4,
      S_TMR1 = 3'd5,
      S_FIFO = 3'd6,
      S_SER  = 3'd7
   } src_e;

   typedef struct packed {
      logic cmd_en;
      logic out_en;
      logic in_en;
      logic in_full_sel;
      logic out_empty_sel;
   } slave_ctl_t;

   // slot in the vector table (vector = base + slot * stride)
   function automatic int unsigned vec_slot(input src_e s);
      case (s)
         S_EXT0:  return 0;
         S_TMR0:  return 1;
         S_EXT1:  return 2;
         S_TMR1:  return 3;
         S_SER:   return 4;
         S_FIFO:  return 5;
         S_DMA0:  return 6;
         default: return 7;
      endcase
   endfunction

endpackage

// File: rtl/octo_irq_cfg.sv
module octo_irq_cfg
   import octo_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_AW-1:0] addr,
   input  logic [CFG_DW-1:0] wdata,
   output logic              glob_en,
   output logic [NSRC-1:0]   src_en,
   output logic [NSRC-1:0]   src_hi,
   output slave_ctl_t        sctl
);

   localparam int unsigned NLEG = 5;
   localparam int unsigned NADD = 3;

   logic [NLEG-1:0] leg_en_q;
   logic [NLEG-1:0] leg_pr_q;
   logic [NADD-1:0] add_en_q;
   logic [NADD-1:0] add_pr_q;
   logic            glob_q;
   slave_ctl_t      sctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         leg_en_q <= '0;
         leg_pr_q <= '0;
         add_en_q <= '0;
         add_pr_q <= '0;
         glob_q   <= 1'b0;
         sctl_q   <= '0;
      end else if (we) begin
         case (addr)
            2'd0: begin
               leg_en_q <= wdata[NLEG-1:0];
               glob_q   <= wdata[7];
            end
            2'd1: leg_pr_q <= wdata[NLEG-1:0];
            2'd2: begin
               add_en_q <= wdata[NADD-1:0];
               add_pr_q <= wdata[4 +: NADD];
            end
            default: sctl_q <= slave_ctl_t'(wdata[$bits(slave_ctl_t)-1:0]);
         endcase
      end
   end

   // legacy bits: 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial
   // added bits : 0 fifo, 1 dma0, 2 dma1
   always_comb begin
      src_en[S_EXT0] = leg_en_q[0];
      src_en[S_TMR0] = leg_en_q[1];
      src_en[S_EXT1] = leg_en_q[2];
      src_en[S_TMR1] = leg_en_q[3];
      src_en[S_SER]  = leg_en_q[4];
      src_en[S_FIFO] = add_en_q[0];
      src_en[S_DMA0] = add_en_q[1];
      src_en[S_DMA1] = add_en_q[2];
      src_hi[S_EXT0] = leg_pr_q[0];
      src_hi[S_TMR0] = leg_pr_q[1];
      src_hi[S_EXT1] = leg_pr_q[2];
      src_hi[S_TMR1] = leg_pr_q[3];
      src_hi[S_SER]  = leg_pr_q[4];
      src_hi[S_FIFO] = add_pr_q[0];
      src_hi[S_DMA0] = add_pr_q[1];
      src_hi[S_DMA1] = add_pr_q[2];
   end

   assign glob_en = glob_q;
   assign sctl    = sctl_q;

endmodule

// File: rtl/octo_irq_fifo_req.sv
module octo_irq_fifo_req
   import octo_irq_pkg::*;
(
   input  slave_ctl_t sctl,
   input  logic       in_full,
   input  logic       in_empty,
   input  logic       out_full,
   input  logic       out_empty,
   input  logic       cmd_pending,
   output logic       fifo_req
);

   logic in_cond;
   logic out_cond;

   assign in_cond  = sctl.in_full_sel   ? in_full   : !in_empty;
   assign out_cond = sctl.out_empty_sel ? out_empty : !out_full;

   assign fifo_req = (sctl.in_en  && in_cond)
                   | (sctl.out_en && out_cond)
                   | (sctl.cmd_en && cmd_pending);

endmodule

// File: rtl/octo_irq_pend.sv
module octo_irq_pend #(
   parameter int unsigned N         = 8,
   parameter logic [N-1:0] EDGE_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);

   for (genvar i = 0; i < N; i++) begin : g_src
      if (EDGE_MASK[i]) begin : g_edge
         logic samp_q;
         logic pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               samp_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               samp_q <= raw[i];
               pend_q <= (pend_q && !clr[i]) || (raw[i] && !samp_q);
            end
         end
         assign pend[i] = pend_q;
      end else begin : g_level
         logic lvl_q;
         logic clr_unused;
         assign clr_unused = clr[i];
         always_ff @(posedge clk) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= raw[i];
         end
         assign pend[i] = lvl_q;
      end
   end

endmodule

// File: rtl/octo_irq_first.sv
module octo_irq_first #(
   parameter  int unsigned N  = 8,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);

   // lowest index wins
   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/octo_irq_ctrl.sv
module octo_irq_ctrl
   import octo_irq_pkg::*;
#(
   parameter int unsigned     VEC_W      = 8,
   parameter int unsigned     VEC_BASE   = 3,
   parameter int unsigned     VEC_STRIDE = 8,
   parameter logic [NSRC-1:0] EDGE_MASK  = 8'h3F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_ext0,
   input  logic              req_tmr0,
   input  logic              req_dma0,
   input  logic              req_ext1,
   input  logic              req_dma1,
   input  logic              req_tmr1,
   input  logic              req_serial,
   input  logic              in_full,
   input  logic              in_empty,
   input  logic              out_full,
   input  logic              out_empty,
   input  logic              cmd_pending,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic              int_ack,
   input  logic              int_reti,
   output logic              int_req,
   output logic [SRC_W-1:0]  int_src,
   output logic [VEC_W-1:0]  int_vector
);

   localparam int unsigned VEC_TOP = VEC_BASE + (NSRC - 1) * VEC_STRIDE;

   if (VEC_W > 16) begin : g_bad_w
      $error("VEC_W above 16 is not supported");
   end
   if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector table does not fit in VEC_W bits");
   end
   if (EDGE_MASK[S_FIFO]) begin : g_bad_edge
      $error("the FIFO source must be level type");
   end

   logic            glob_en;
   logic [NSRC-1:0] src_en;
   logic [NSRC-1:0] src_hi;
   slave_ctl_t      sctl;
   logic            fifo_req;
   logic [NSRC-1:0] raw;
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] clr;
   logic [NSRC-1:0] elig_hi;
   logic [NSRC-1:0] elig_lo;
   logic            hi_found;
   logic            lo_found;
   logic [SRC_W-1:0] hi_idx;
   logic [SRC_W-1:0] lo_idx;
   logic [SRC_W-1:0] win;
   logic             any;
   logic [VEC_W-1:0] win_vec;

   logic             req_q;
   logic [SRC_W-1:0] src_q;
   logic [VEC_W-1:0] vec_q;
   logic             lvl_q;
   logic             isv_hi_q;
   logic             isv_lo_q;
   logic             ack_take;

   octo_irq_cfg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .glob_en (glob_en),
      .src_en  (src_en),
      .src_hi  (src_hi),
      .sctl    (sctl)
   );

   octo_irq_fifo_req u_fifo (
      .sctl        (sctl),
      .in_full     (in_full),
      .in_empty    (in_empty),
      .out_full    (out_full),
      .out_empty   (out_empty),
      .cmd_pending (cmd_pending),
      .fifo_req    (fifo_req)
   );

   always_comb begin
      raw         = '0;
      raw[S_EXT0] = req_ext0;
      raw[S_TMR0] = req_tmr0;
      raw[S_DMA0] = req_dma0;
      raw[S_EXT1] = req_ext1;
      raw[S_DMA1] = req_dma1;
      raw[S_TMR1] = req_tmr1;
      raw[S_FIFO] = fifo_req;
      raw[S_SER]  = req_serial;
   end

   assign ack_take = int_ack && req_q;

   always_comb begin
      clr = '0;
      if (ack_take) clr[src_q] = 1'b1;
   end

   octo_irq_pend #(
      .N         (NSRC),
      .EDGE_MASK (EDGE_MASK)
   ) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw),
      .clr   (clr),
      .pend  (pend)
   );

   // eligibility per level under the in-service rules
   assign elig_hi = pend & src_en &  src_hi & {NSRC{glob_en && !isv_hi_q}};
   assign elig_lo = pend & src_en & ~src_hi & {NSRC{glob_en && !isv_hi_q && !isv_lo_q}};

   octo_irq_first #(.N(NSRC)) u_first_hi (
      .req   (elig_hi),
      .found (hi_found),
      .idx   (hi_idx)
   );

   octo_irq_first #(.N(NSRC)) u_first_lo (
      .req   (elig_lo),
      .found (lo_found),
      .idx   (lo_idx)
   );

   assign win = hi_found ? hi_idx : lo_idx;
   assign any = hi_found || lo_found;

   always_comb begin
      int unsigned v;
      v       = VEC_BASE + vec_slot(src_e'(win)) * VEC_STRIDE;
      win_vec = VEC_W'(v);
   end

   // presented request, held until acknowledged
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         src_q <= '0;
         vec_q <= '0;
         lvl_q <= 1'b0;
      end else if (req_q) begin
         if (int_ack) req_q <= 1'b0;
      end else begin
         req_q <= any;
         if (any) begin
            src_q <= win;
            vec_q <= win_vec;
            lvl_q <= hi_found;
         end
      end
   end

   // in-service flags: return pops the top level, acknowledge pushes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isv_hi_q <= 1'b0;
         isv_lo_q <= 1'b0;
      end else begin
         logic hi_n;
         logic lo_n;
         hi_n = isv_hi_q;
         lo_n = isv_lo_q;
         if (int_reti) begin
            if (hi_n) hi_n = 1'b0;
            else      lo_n = 1'b0;
         end
         if (ack_take) begin
            if (lvl_q) hi_n = 1'b1;
            else       lo_n = 1'b1;
         end
         isv_hi_q <= hi_n;
         isv_lo_q <= lo_n;
      end
   end

   assign int_req    = req_q;
   assign int_src    = src_q;
   assign int_vector = vec_q;

endmodule

// File: rtl/octo_irq_chk.sv
module octo_irq_chk (
   input logic clk,
   input logic rst_n,
   input logic int_req,
   input logic int_ack,
   input logic int_reti,
   input logic [2:0] int_src,
   input logic [7:0] int_vector,
   input logic glob_en,
   input logic isv_hi,
   input logic isv_lo
);

   // R10
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_req && !int_ack |=> int_req && $stable(int_src) && $stable(int_vector));

   // R11
   ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_req && int_ack |=> !int_req);

   // R11
   idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && !int_req && !int_reti |=> $stable({isv_hi, isv_lo}));

   // R3
   master_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en && !int_req |=> !int_req);

   // R13
   high_isv_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isv_hi && !int_req |=> !int_req);

endmodule

bind octo_irq_ctrl octo_irq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .int_req    (int_req),
   .int_ack    (int_ack),
   .int_reti   (int_reti),
   .int_src    (int_src),
   .int_vector (int_vector),
   .glob_en    (glob_en),
   .isv_hi     (isv_hi_q),
   .isv_lo     (isv_lo_q)
);

// File: tb/test_octo_irq_ctrl.sv
`timescale 1ns/1ps
module test_octo_irq_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_ext0 = 0, req_tmr0 = 0, req_dma0 = 0, req_ext1 = 0;
   logic req_dma1 = 0, req_tmr1 = 0, req_serial = 0;
   logic in_full = 0, in_empty = 1, out_full = 0, out_empty = 0, cmd_pending = 0;
   logic cfg_we = 0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic int_ack = 0, int_reti = 0;
   logic int_req;
   logic [2:0] int_src;
   logic [7:0] int_vector;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   octo_irq_ctrl i_octo_irq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_ext0(req_ext0), .req_tmr0(req_tmr0), .req_dma0(req_dma0),
      .req_ext1(req_ext1), .req_dma1(req_dma1), .req_tmr1(req_tmr1),
      .req_serial(req_serial),
      .in_full(in_full), .in_empty(in_empty), .out_full(out_full),
      .out_empty(out_empty), .cmd_pending(cmd_pending),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .int_ack(int_ack), .int_reti(int_reti),
      .int_req(int_req), .int_src(int_src), .int_vector(int_vector)
   );

   // lines: 0 ext0,1 tmr0,2 dma0,3 ext1,4 dma1,5 tmr1,6 serial
   // ff   : 4 cmd,3 out_full,2 out_empty,1 in_full,0 in_empty
   typedef struct packed {
      logic [7:0] en0;
      logic [7:0] pr1;
      logic [7:0] x2;
      logic [7:0] sc3;
      logic [6:0] lines;
      logic [4:0] ff;
      logic       exp_req;
      logic [7:0] exp_vec;
      logic [7:0] rq;
   } row_t;

   localparam int NROW = 21;
   localparam row_t TBL [NROW] = '{
      '{8'h9F, 8'h00, 8'h07, 8'h00, 7'h7F, 5'h01, 1'b1, 8'h03, 8'd5}, // R5 all at low
      '{8'h9F, 8'h00, 8'h07, 8'h00, 7'h7E, 5'h01, 1'b1, 8'h0B, 8'd5}, // R5
      '{8'h9F, 8'h00, 8'h07, 8'h00, 7'h7C, 5'h01, 1'b1, 8'h33, 8'd5}, // R5
      '{8'h9F, 8'h00, 8'h07, 8'h00, 7'h70, 5'h01, 1'b1, 8'h3B, 8'd5}, // R5
      '{8'h9F, 8'h00, 8'h07, 8'h00, 7'h60, 5'h01, 1'b1, 8'h1B, 8'd6}, // R6
      '{8'h9F, 8'h00, 8'h07, 8'h00, 7'h40, 5'h01, 1'b1, 8'h23, 8'd6}, // R6
      '{8'h9F, 8'h10, 8'h07, 8'h00, 7'h7F, 5'h01, 1'b1, 8'h23, 8'd4}, // R4 serial high
      '{8'h9F, 8'h08, 8'h47, 8'h00, 7'h7F, 5'h01, 1'b1, 8'h3B, 8'd4}, // R4 dma1 before tmr1
      '{8'h1F, 8'h00, 8'h07, 8'h00, 7'h7F, 5'h01, 1'b0, 8'h00, 8'd3}, // R3 master off
      '{8'h90, 8'h00, 8'h00, 8'h00, 7'h7F, 5'h01, 1'b1, 8'h23, 8'd2}, // R2 only serial
      '{8'h80, 8'h00, 8'h01, 8'h06, 7'h00, 5'h02, 1'b1, 8'h2B, 8'd7}, // R7 full, sel full
      '{8'h80, 8'h00, 8'h01, 8'h06, 7'h00, 5'h00, 1'b0, 8'h00, 8'd7}, // R7
      '{8'h80, 8'h00, 8'h01, 8'h04, 7'h00, 5'h00, 1'b1, 8'h2B, 8'd7}, // R7 not empty
      '{8'h80, 8'h00, 8'h01, 8'h04, 7'h00, 5'h01, 1'b0, 8'h00, 8'd7}, // R7
      '{8'h80, 8'h00, 8'h01, 8'h09, 7'h00, 5'h05, 1'b1, 8'h2B, 8'd8}, // R8 empty
      '{8'h80, 8'h00, 8'h01, 8'h09, 7'h00, 5'h01, 1'b0, 8'h00, 8'd8}, // R8
      '{8'h80, 8'h00, 8'h01, 8'h08, 7'h00, 5'h01, 1'b1, 8'h2B, 8'd8}, // R8 not full
      '{8'h80, 8'h00, 8'h01, 8'h08, 7'h00, 5'h09, 1'b0, 8'h00, 8'd8}, // R8
      '{8'h80, 8'h00, 8'h01, 8'h10, 7'h00, 5'h11, 1'b1, 8'h2B, 8'd9}, // R9 command
      '{8'h80, 8'h00, 8'h01, 8'h00, 7'h00, 5'h11, 1'b0, 8'h00, 8'd9}, // R9
      '{8'h80, 8'h00, 8'h00, 8'h10, 7'h00, 5'h11, 1'b0, 8'h00, 8'd9}  // R9
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      {req_ext0, req_tmr0, req_dma0, req_ext1, req_dma1, req_tmr1, req_serial} = '0;
      {cmd_pending, out_full, out_empty, in_full, in_empty} = 5'h01;
      int_ack = 0; int_reti = 0; cfg_we = 0;
      tick(2);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      tick(1);
      cfg_we = 0;
   endtask

   task automatic pulse_ack();
      int_ack = 1; tick(1); int_ack = 0;
   endtask

   task automatic pulse_reti();
      int_reti = 1; tick(1); int_reti = 0;
   endtask

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic expect_vec(input string rq, input logic [7:0] v);
      chk(rq, {31'd0, int_req}, 32'd1);
      chk(rq, {24'd0, int_vector}, {24'd0, v});
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      chk("R1 req", {31'd0, int_req}, 32'd0);
      chk("R1 vec", {24'd0, int_vector}, 32'd0);
      chk("R1 src", {29'd0, int_src}, 32'd0);
      req_ext0 = 1; tick(3);
      chk("R1 cfg cleared", {31'd0, int_req}, 32'd0);

      for (int r = 0; r < NROW; r++) begin
         do_reset();
         wr(2'd0, TBL[r].en0);
         wr(2'd1, TBL[r].pr1);
         wr(2'd2, TBL[r].x2);
         wr(2'd3, TBL[r].sc3);
         {req_serial, req_tmr1, req_dma1, req_ext1, req_dma0, req_tmr0, req_ext0} = TBL[r].lines;
         {cmd_pending, out_full, out_empty, in_full, in_empty} = TBL[r].ff;
         tick(3);
         chk($sformatf("R%0d row %0d req", TBL[r].rq, r), {31'd0, int_req}, {31'd0, TBL[r].exp_req});
         if (TBL[r].exp_req)
            chk($sformatf("R%0d row %0d vec", TBL[r].rq, r), {24'd0, int_vector}, {24'd0, TBL[r].exp_vec});
      end

      // nesting and preemption: tmr0 and dma0 high, rest low
      do_reset();
      wr(2'd0, 8'h9F);
      wr(2'd1, 8'h02);
      wr(2'd2, 8'h22);
      req_ext1 = 1; tick(1);
      chk("R10 one edge later", {31'd0, int_req}, 32'd0);
      tick(1);
      expect_vec("R10 ext1", 8'h13);
      chk("R5 src ext1", {29'd0, int_src}, 32'd3);
      req_ext0 = 1; tick(3);
      expect_vec("R10 held", 8'h13);
      pulse_ack(); tick(3);
      chk("R13 low blocks low", {31'd0, int_req}, 32'd0);
      req_tmr0 = 1; tick(3);
      expect_vec("R13 high preempts", 8'h0B);
      pulse_ack();
      req_dma0 = 1; tick(3);
      chk("R13 high blocks all", {31'd0, int_req}, 32'd0);
      pulse_reti(); tick(2);
      expect_vec("R13 reti pops high", 8'h33);
      pulse_ack(); pulse_reti(); pulse_reti(); tick(2);
      expect_vec("R13 reti pops low", 8'h03);
      pulse_ack(); pulse_reti(); tick(3);
      chk("R11 edge cleared", {31'd0, int_req}, 32'd0);
      req_ext1 = 0; tick(1); req_ext1 = 1; tick(3);
      expect_vec("R11 new edge", 8'h13);

      // level source survives acknowledge
      do_reset();
      wr(2'd0, 8'h80);
      wr(2'd2, 8'h01);
      wr(2'd3, 8'h04);
      in_empty = 0; tick(3);
      expect_vec("R12 fifo", 8'h2B);
      pulse_ack(); pulse_reti(); tick(2);
      expect_vec("R12 still pending", 8'h2B);
      pulse_ack(); in_empty = 1; pulse_reti(); tick(3);
      chk("R12 condition gone", {31'd0, int_req}, 32'd0);

      // acknowledge with nothing presented
      do_reset();
      wr(2'd0, 8'h81);
      pulse_ack(); tick(1);
      req_ext0 = 1; tick(3);
      expect_vec("R11 idle ack ignored", 8'h03);

      done = 1;
      finish_run();
   end

endmodule